// File: doc/BRIEF.md
# Two-Pulse Sample Reconstruction Engine

This block turns discriminated sensor samples into compact pulse records. Every accepted cycle brings one 64-bit sample for each of eight channels. Each bit of a sample is one time slice, and bit 0 is the earliest. For each channel the block builds a vector of rising edges and a vector of falling edges. It then searches those vectors for the first set bit, once from the low end and once from the high end. From the four indices it gets the earliest pulse and the latest pulse in the sample, each as a start position and a width. It also gives a per-channel hit count of 0, 1 or 2.

Samples are accepted back to back, one per clock, when the valid strobe is high. Results come out a fixed three cycles later. The block keeps the last bit of each channel's previous accepted sample, so a pulse that carries over from one crossing into the next is not mistaken for a new rising edge.

Top module: `pulse_pair_recon`

## Requirements
- R1: A sample accepted with `in_valid` high at clock edge k appears with `out_valid` high after edge k+3. With `in_valid` high every cycle, one result is produced per cycle.
- R2: A rising edge at bit i is a 1 at bit i with a 0 at bit i-1. For bit 0, the bit compared against is bit 63 of the channel's previous accepted sample, which is 0 after reset. Samples presented while `in_valid` is low do not change this history.
- R3: Pulse 1 starts at the lowest rising edge. Its width is the distance from that edge to the first falling edge above it.
- R4: When a sample holds two or more pulses, pulse 2 is the one with the highest rising edge. Pulses between the first and the last are not reported.
- R5: With one pulse only, pulse 2 is all zero and the hit count is 1. With no rising edge, both pulses are all zero and the hit count is 0. With two or more pulses the hit count is 2. The value 3 never occurs.
- R6: A pulse still high at bit 63 is measured up to the end of the sample, so its width is 64 minus its position. Any width above 31 is reported as 31.
- R7: Layout. Channel c uses `out_record[22c+21:22c]`. Pulse 1 is in the low 11 bits and pulse 2 in the high 11 bits. Within a pulse, the width is in bits [4:0] and the position in bits [10:5]. Channel c's hit count is `out_hits[2c+1:2c]`.
- R8: After reset, `out_valid`, `out_record` and `out_hits` are zero. While `out_valid` is low, `out_record` and `out_hits` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Qualifies `in_samples` this cycle |
| in_samples | input | 512 | Eight 64-bit samples; channel c in bits [64c+63:64c] |
| out_valid | output | 1 | Result record valid |
| out_record | output | 176 | Packed pulse records, 22 bits per channel |
| out_hits | output | 16 | Hit count per channel, 2 bits each |

## Verification
The bench targets several corner cases:
- A pulse that carries over from the previous sample must not produce a rising edge at bit 0. A design that ignored the history, or that updated it on idle cycles, would report a false pulse at position 0.
- Samples with three pulses check that the middle pulse is skipped. A design that paired edges wrongly would report the middle pulse or a negative width.
- Pulses that reach bit 63 and pulses wider than 31 check the open-end width and saturation. A design that got these wrong would wrap the width to a small number.
- Single-pulse samples check that pulse 2 is zeroed. A design that got this wrong would report the same pulse twice.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int SAMPLE_W = 64;
  localparam int IDX_W    = $clog2(SAMPLE_W);
  localparam int WID_W    = 5;
  localparam int PULSE_W  = IDX_W + WID_W;
  localparam int CH_W     = 2 * PULSE_W;
  localparam int HIT_W    = 2;
  localparam int WID_MAX  = (1 << WID_W) - 1;

  typedef struct packed {
    logic             found;
    logic [IDX_W-1:0] idx;
  } edge_idx_t;

  typedef struct packed {
    logic [IDX_W-1:0] pos;
    logic [WID_W-1:0] wid;
  } pulse_t;

  // lowest set bit
  function automatic edge_idx_t scan_low(input logic [SAMPLE_W-1:0] v);
    edge_idx_t r;
    r = '0;
    for (int i = SAMPLE_W - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.found = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction

  // highest set bit
  function automatic edge_idx_t scan_high(input logic [SAMPLE_W-1:0] v);
    edge_idx_t r;
    r = '0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (v[i]) begin
        r.found = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction

  // bits strictly above position p
  function automatic logic [SAMPLE_W-1:0] above(input logic [IDX_W-1:0] p);
    logic [SAMPLE_W-1:0] m;
    for (int i = 0; i < SAMPLE_W; i++) m[i] = (i > int'(p));
    return m;
  endfunction

  // end minus start, end of sample when no fall, saturated
  function automatic logic [WID_W-1:0] span(input edge_idx_t fe,
                                            input logic [IDX_W-1:0] re);
    logic [IDX_W:0] stop;
    logic [IDX_W:0] d;
    stop = fe.found ? {1'b0, fe.idx} : (IDX_W+1)'(SAMPLE_W);
    d    = stop - {1'b0, re};
    return (d > (IDX_W+1)'(WID_MAX)) ? WID_W'(WID_MAX) : d[WID_W-1:0];
  endfunction
endpackage

// File: rtl/pr_edge_extract.sv
module pr_edge_extract
  import pr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] rise_q,
  output logic [SAMPLE_W-1:0] fall_q
);
  logic                last_bit;
  logic [SAMPLE_W-1:0] delayed;
  logic [SAMPLE_W-1:0] rise_d;
  logic [SAMPLE_W-1:0] fall_d;

  always_comb begin
    delayed = {sample[SAMPLE_W-2:0], last_bit};
    rise_d  = sample & ~delayed;
    fall_d  = ~sample & delayed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bit <= 1'b0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (take) begin
      last_bit <= sample[SAMPLE_W-1];
      rise_q   <= rise_d;
      fall_q   <= fall_d;
    end
  end
endmodule

// File: rtl/pr_edge_search.sv
module pr_edge_search
  import pr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] rise,
  input  logic [SAMPLE_W-1:0] fall,
  output edge_idx_t           lo_re_q,
  output edge_idx_t           lo_fe_q,
  output edge_idx_t           hi_re_q,
  output edge_idx_t           hi_fe_q
);
  edge_idx_t lo_re, lo_fe, hi_re, hi_fe_raw, hi_fe;

  always_comb begin
    lo_re     = scan_low(rise);
    lo_fe     = scan_low(fall & above(lo_re.idx));
    hi_re     = scan_high(rise);
    hi_fe_raw = scan_high(fall);
    hi_fe     = hi_fe_raw;
    hi_fe.found = hi_fe_raw.found && (hi_fe_raw.idx > hi_re.idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_re_q <= '0;
      lo_fe_q <= '0;
      hi_re_q <= '0;
      hi_fe_q <= '0;
    end else if (en) begin
      lo_re_q <= lo_re;
      lo_fe_q <= lo_fe;
      hi_re_q <= hi_re;
      hi_fe_q <= hi_fe;
    end
  end
endmodule

// File: rtl/pr_pulse_pack.sv
module pr_pulse_pack
  import pr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  edge_idx_t        lo_re,
  input  edge_idx_t        lo_fe,
  input  edge_idx_t        hi_re,
  input  edge_idx_t        hi_fe,
  output logic [CH_W-1:0]  rec_q,
  output logic [HIT_W-1:0] hits_q
);
  pulse_t           first_p, last_p;
  logic [HIT_W-1:0] hits_d;

  always_comb begin
    first_p = '0;
    last_p  = '0;
    hits_d  = '0;
    if (lo_re.found) begin
      first_p.pos = lo_re.idx;
      first_p.wid = span(lo_fe, lo_re.idx);
      if (hi_re.idx == lo_re.idx) begin
        hits_d = HIT_W'(1);
      end else begin
        hits_d     = HIT_W'(2);
        last_p.pos = hi_re.idx;
        last_p.wid = span(hi_fe, hi_re.idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      hits_q <= '0;
    end else if (en) begin
      rec_q  <= {last_p, first_p};
      hits_q <= hits_d;
    end
  end
endmodule

// File: rtl/pulse_pair_recon.sv
module pulse_pair_recon
  import pr_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int IN_W  = N_CH * SAMPLE_W,
  localparam int REC_W = N_CH * CH_W,
  localparam int HITS_W = N_CH * HIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_samples,
  output logic              out_valid,
  output logic [REC_W-1:0]  out_record,
  output logic [HITS_W-1:0] out_hits
);
  logic st1_valid, st2_valid, st3_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_valid <= 1'b0;
      st2_valid <= 1'b0;
      st3_valid <= 1'b0;
    end else begin
      st1_valid <= in_valid;
      st2_valid <= st1_valid;
      st3_valid <= st2_valid;
    end
  end

  assign out_valid = st3_valid;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] rise, fall;
    edge_idx_t lo_re, lo_fe, hi_re, hi_fe;

    pr_edge_extract u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (in_valid),
      .sample (in_samples[c*SAMPLE_W +: SAMPLE_W]),
      .rise_q (rise),
      .fall_q (fall)
    );

    pr_edge_search u_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (st1_valid),
      .rise    (rise),
      .fall    (fall),
      .lo_re_q (lo_re),
      .lo_fe_q (lo_fe),
      .hi_re_q (hi_re),
      .hi_fe_q (hi_fe)
    );

    pr_pulse_pack u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (st2_valid),
      .lo_re  (lo_re),
      .lo_fe  (lo_fe),
      .hi_re  (hi_re),
      .hi_fe  (hi_fe),
      .rec_q  (out_record[c*CH_W +: CH_W]),
      .hits_q (out_hits[c*HIT_W +: HIT_W])
    );
  end
endmodule

// File: rtl/pr_checker.sv
module pr_checker
  import pr_pkg::*;
#(
  parameter int N_CH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [N_CH*CH_W-1:0]    out_record,
  input logic [N_CH*HIT_W-1:0]   out_hits
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_record) && $stable(out_hits)));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    logic [HIT_W-1:0] h;
    pulse_t           p1, p2;
    assign h  = out_hits[c*HIT_W +: HIT_W];
    assign p1 = out_record[c*CH_W +: PULSE_W];
    assign p2 = out_record[c*CH_W + PULSE_W +: PULSE_W];

    a_r5_no_three: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (h != 2'd3));

    a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && h == 2'd0) |-> (p1 == '0 && p2 == '0));

    a_r5_single_p2_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && h == 2'd1) |-> (p2 == '0 && p1.wid != '0));

    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && h == 2'd2) |-> (p1.pos < p2.pos && p1.wid != '0 && p2.wid != '0));

    a_r3_fits: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && h != 2'd0) |-> ({1'b0, p1.pos} + p1.wid <= SAMPLE_W));
  end
endmodule

bind pulse_pair_recon pr_checker #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_record (out_record),
  .out_hits   (out_hits)
);

// File: tb/pulse_pair_recon_tb.sv
module pulse_pair_recon_tb;
  localparam int NC = 8;
  localparam int SW = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [NC*SW-1:0] in_samples = '0;
  logic             out_valid;
  logic [NC*22-1:0] out_record;
  logic [NC*2-1:0]  out_hits;

  always #5 clk = ~clk;

  pulse_pair_recon u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_samples (in_samples),
    .out_valid  (out_valid),
    .out_record (out_record),
    .out_hits   (out_hits)
  );

  typedef struct {
    logic [NC*22-1:0] rec;
    logic [NC*2-1:0]  hits;
    int               cyc;
    string            tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [NC-1:0] hist = '0;
  logic [NC*22-1:0] last_rec = '0;
  logic [NC*2-1:0]  last_hits = '0;
  bit          seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [SW-1:0] run(int p, int n);
    logic [SW-1:0] m = '0;
    for (int i = p; i < p + n && i < SW; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int run_len(logic [SW-1:0] s, int p);
    int n = 0;
    for (int j = p; j < SW && s[j]; j++) n++;
    return (n > 31) ? 31 : n;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [NC*SW-1:0] smp, string tag);
    exp_t e;
    e.rec = '0; e.hits = '0; e.tag = tag;
    for (int c = 0; c < NC; c++) begin
      logic [SW-1:0] s;
      logic prev;
      int cnt, fp, lp;
      s = smp[c*SW +: SW];
      prev = hist[c]; cnt = 0; fp = 0; lp = 0;
      for (int i = 0; i < SW; i++) begin
        if (s[i] && !prev) begin
          cnt++;
          if (cnt == 1) fp = i;
          lp = i;
        end
        prev = s[i];
      end
      hist[c] = s[SW-1];
      if (cnt >= 1) e.rec[c*22 +: 11] = {6'(fp), 5'(run_len(s, fp))};
      if (cnt >= 2) e.rec[c*22+11 +: 11] = {6'(lp), 5'(run_len(s, lp))};
      e.hits[c*2 +: 2] = (cnt > 2) ? 2'd2 : 2'(cnt);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_samples = smp;
    e.cyc = cyc;
    sb.push_back(e);
  endtask

  task automatic idle(int n, logic [NC*SW-1:0] junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_samples = junk;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R1 unexpected output", 256'(1), 256'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({"R1 latency ", e.tag}, 256'(cyc), 256'(e.cyc + 3));
          check({"R7 record ", e.tag}, 256'(out_record), 256'(e.rec));
          check({"R5 hits ", e.tag}, 256'(out_hits), 256'(e.hits));
        end
        last_rec = out_record; last_hits = out_hits; seen = 1;
      end else if (rst_n && seen) begin
        check("R8 hold record", 256'(out_record), 256'(last_rec));
        check("R8 hold hits", 256'(out_hits), 256'(last_hits));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [NC*SW-1:0] v;
    repeat (3) @(negedge clk);
    check("R8 reset valid", 256'(out_valid), 256'(0));
    check("R8 reset record", 256'(out_record), 256'(0));
    check("R8 reset hits", 256'(out_hits), 256'(0));
    rst_n = 1'b1;
    idle(2, '0);

    send('0, "R5 empty");

    v = '0;
    v[0*SW +: SW] = run(10, 5);
    v[1*SW +: SW] = run(0, 3);
    v[2*SW +: SW] = run(5, 2) | run(20, 4);
    v[3*SW +: SW] = run(3, 1) | run(30, 2) | run(50, 6);
    v[4*SW +: SW] = run(20, 40);
    v[5*SW +: SW] = run(50, 14);
    v[6*SW +: SW] = run(0, 64);
    v[7*SW +: SW] = run(62, 2);
    send(v, "R3 R4 R6 mixed");

    v = '0;
    v[0*SW +: SW] = run(63, 1);
    v[5*SW +: SW] = run(0, 64);
    v[6*SW +: SW] = run(0, 4) | run(10, 2);
    send(v, "R2 carry-over R6 open end");

    idle(3, {NC*SW{1'b1}});

    v = '0;
    v[0*SW +: SW] = run(0, 2);
    v[1*SW +: SW] = run(0, 2);
    v[2*SW +: SW] = run(0, 1) | run(2, 1) | run(63, 1);
    send(v, "R2 idle ignored");
    idle(5, '0);

    for (int k = 0; k < 60; k++) begin
      for (int c = 0; c < NC; c++)
        v[c*SW +: SW] = {$urandom, $urandom} & {$urandom, $urandom} |
                        ((k % 3 == 0) ? run(40 + c, 30) : '0);
      send(v, "R3 R4 random");
      if (k % 7 == 6) idle(2, {$urandom, $urandom, $urandom, $urandom,
                              $urandom, $urandom, $urandom, $urandom,
                              $urandom, $urandom, $urandom, $urandom,
                              $urandom, $urandom, $urandom, $urandom});
    end
    idle(8, '0);
    check("R1 all results returned", 256'(sb.size()), 256'(0));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule